// File: doc/BRIEF.md
# Vector Widening Add/Subtract Unit

This block decodes one family of 32-bit vector instructions and runs them over a fixed-width vector. In every lane, the unit adds or subtracts a narrow value to or from a wide element of the first source. The narrow value comes from the second source. An instruction bit picks either the lower or the upper half of each wide lane of the second source. The narrow value is then sign-extended or zero-extended to the lane width. The arithmetic wraps at the lane width.

A producer presents an instruction word, the two source vectors and a valid strobe in the same cycle. One clock later the unit returns the following:
- the result vector,
- the destination register index taken from the word,
- a valid flag,
- an illegal-encoding flag.

The illegal flag is raised for words of the family that carry the reserved size code. For those words the result register is not written. Words outside the family produce neither flag.

Top module: `vwide_addsub`

## Requirements
- R1: A word is accepted only when bits [31:24] are 8'h45, bit 21 is 0 and bits [15:13] are 3'b010. Any other word, and any cycle with `inValid` low, leaves both `outValid` and `outIllegal` low in the next cycle and leaves `outResult` unchanged.
- R2: An accepted word with size bits [23:22] = 0 sets `outIllegal` and clears `outValid` in the next cycle, and does not change `outResult`.
- R3: Size bits [23:22] give the lane width: 1 gives 16-bit lanes, 2 gives 32-bit lanes and 3 gives 64-bit lanes. The narrow value is half the lane width.
- R4: When bit 10 is 0, the narrow value is the lower half of each lane of `srcB`.
- R5: When bit 10 is 1, the narrow value is the upper half of each lane of `srcB`. The lane is shifted right by the narrow width in bits.
- R6: When bit 11 is 0, the narrow value is sign-extended. When bit 11 is 1, it is zero-extended. For example, a 16-bit lane of `srcB` holding 16'h8000 with the upper half selected gives an operand of -128 when signed and 128 when unsigned.
- R7: When bit 12 is 0, the unit adds: `srcA` lane plus the extended value. When bit 12 is 1, it subtracts: `srcA` lane minus the extended value, never the reverse.
- R8: Each lane result wraps modulo 2 to the power of the lane width. There is no saturation and no carry into the next lane.
- R9: For a legal word with `inValid` high, `outValid`, `outResult` and `outRd` are set one cycle later. `outRd` equals bits [4:0] of the word.
- R10: While `rstN` is low at a clock edge, `outValid`, `outIllegal`, `outRd` and `outResult` are all cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | The instruction and operands are present this cycle |
| instr | input | 32 | Instruction word |
| srcA | input | VW (128) | Wide first source vector |
| srcB | input | VW (128) | Second source vector that supplies the narrow halves |
| outValid | output | 1 | A result was written on the last clock |
| outIllegal | output | 1 | The last accepted word used the reserved size |
| outRd | output | 5 | Destination register index |
| outResult | output | VW (128) | Result vector |

## Verification
Half selection and sign extension act together on the same lane bits. The bench therefore places 16'h8000 in a 16-bit lane and selects the upper half. It expects -128 for the signed variants and 128 for the unsigned ones. The 8'h80 sign bit is also placed at each half boundary of the random and pattern sweeps, so a shift by the byte count or a wrong extension shows up as a mismatch against the arithmetic model. A second collision is an illegal word issued directly after a legal one. In that case the flag must rise while the result of the previous word stays on the output unchanged.

// File: rtl/vwide_pkg.sv
package vwide_pkg;

  typedef enum logic [1:0] {
    SZ_NONE = 2'd0,
    SZ_H    = 2'd1,
    SZ_S    = 2'd2,
    SZ_D    = 2'd3
  } laneSize_e;

  localparam logic [7:0] FAMILY_HI  = 8'h45;
  localparam logic [2:0] FAMILY_MID = 3'b010;

  typedef struct packed {
    logic      write;
    logic      sub;
    logic      uns;
    logic      top;
    laneSize_e size;
  } dpCtrl_t;

endpackage

// File: rtl/vwide_lane.sv
module vwide_lane #(
  parameter int LW = 16
) (
  input  logic [LW-1:0] a,
  input  logic [LW-1:0] b,
  input  logic          sub,
  input  logic          uns,
  input  logic          top,
  output logic [LW-1:0] res
);
  localparam int NW = LW / 2;

  logic [NW-1:0] narrow;
  logic [LW-1:0] extended;
  logic          fillBit;

  always_comb begin
    narrow   = top ? b[LW-1:NW] : b[NW-1:0];
    fillBit  = ~uns & narrow[NW-1];
    extended = {{NW{fillBit}}, narrow};
    res      = sub ? (a - extended) : (a + extended);
  end
endmodule

// File: rtl/vwide_ctrl.sv
module vwide_ctrl
  import vwide_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] instr,
  output dpCtrl_t     dpCtrl,
  output logic        outValid,
  output logic        outIllegal,
  output logic [4:0]  outRd
);
  logic      familyHit;
  logic      accepted;
  laneSize_e sizeField;
  logic      unusedRegBits;

  assign unusedRegBits = ^{instr[20:16], instr[9:5]};

  always_comb begin
    familyHit = (instr[31:24] == FAMILY_HI) && !instr[21] &&
                (instr[15:13] == FAMILY_MID);
    accepted  = inValid && familyHit;
    sizeField = laneSize_e'(instr[23:22]);

    dpCtrl.write = accepted && (sizeField != SZ_NONE);
    dpCtrl.sub   = instr[12];
    dpCtrl.uns   = instr[11];
    dpCtrl.top   = instr[10];
    dpCtrl.size  = sizeField;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outIllegal <= 1'b0;
      outRd      <= '0;
    end else begin
      outValid   <= dpCtrl.write;
      outIllegal <= accepted && (sizeField == SZ_NONE);
      if (dpCtrl.write) outRd <= instr[4:0];
    end
  end
endmodule

// File: rtl/vwide_dp.sv
module vwide_dp
  import vwide_pkg::*;
#(
  parameter int VW = 128
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtrl_t       dpCtrl,
  input  logic [VW-1:0] srcA,
  input  logic [VW-1:0] srcB,
  output logic [VW-1:0] outResult
);
  logic [VW-1:0] sizeRes [4];
  logic [VW-1:0] nextRes;

  assign sizeRes[0] = '0;

  for (genvar gs = 1; gs < 4; gs++) begin : g_size
    localparam int LW = 8 << gs;
    localparam int NL = VW / LW;
    for (genvar gl = 0; gl < NL; gl++) begin : g_lane
      vwide_lane #(.LW(LW)) u_lane (
        .a   (srcA[gl*LW +: LW]),
        .b   (srcB[gl*LW +: LW]),
        .sub (dpCtrl.sub),
        .uns (dpCtrl.uns),
        .top (dpCtrl.top),
        .res (sizeRes[gs][gl*LW +: LW])
      );
    end
  end

  always_comb nextRes = sizeRes[dpCtrl.size];

  always_ff @(posedge clk) begin
    if (!rstN)             outResult <= '0;
    else if (dpCtrl.write) outResult <= nextRes;
  end
endmodule

// File: rtl/vwide_addsub.sv
module vwide_addsub
  import vwide_pkg::*;
#(
  parameter int VW = 128
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic [31:0]   instr,
  input  logic [VW-1:0] srcA,
  input  logic [VW-1:0] srcB,
  output logic          outValid,
  output logic          outIllegal,
  output logic [4:0]    outRd,
  output logic [VW-1:0] outResult
);
  dpCtrl_t dpCtrl;

  vwide_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .instr      (instr),
    .dpCtrl     (dpCtrl),
    .outValid   (outValid),
    .outIllegal (outIllegal),
    .outRd      (outRd)
  );

  vwide_dp #(.VW(VW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .dpCtrl    (dpCtrl),
    .srcA      (srcA),
    .srcB      (srcB),
    .outResult (outResult)
  );
endmodule

// File: rtl/vwide_addsub_chk.sv
module vwide_addsub_chk #(
  parameter int VW = 128
) (
  input logic          clk,
  input logic          rstN,
  input logic          inValid,
  input logic [31:0]   instr,
  input logic [VW-1:0] srcA,
  input logic [VW-1:0] srcB,
  input logic          outValid,
  input logic          outIllegal,
  input logic [4:0]    outRd,
  input logic [VW-1:0] outResult
);
  logic hit;
  logic legalIn;
  logic badSize;

  assign hit     = inValid && (instr[31:24] == 8'h45) && !instr[21] && (instr[15:13] == 3'b010);
  assign legalIn = hit && (instr[23:22] != 2'd0);
  assign badSize = hit && (instr[23:22] == 2'd0);

  // R1: no flags after a word outside the family or an idle cycle
  a_r1_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !hit |=> (!outValid && !outIllegal));

  // R2: reserved size raises illegal only
  a_r2_illegal: assert property (@(posedge clk) disable iff (!rstN)
    badSize |=> (outIllegal && !outValid));

  // R2: result register untouched without a legal word
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && !legalIn) |=> $stable(outResult));

  // R9: legal word produces valid and destination one cycle later
  a_r9_valid_rd: assert property (@(posedge clk) disable iff (!rstN)
    legalIn |=> (outValid && outRd == $past(instr[4:0])));

  // R3: 16-bit lane 0, bottom half, signed add
  a_r3_half_add: assert property (@(posedge clk) disable iff (!rstN)
    (legalIn && instr[23:22] == 2'd1 && instr[12:10] == 3'b000) |=>
    (outResult[15:0] == $past(srcA[15:0] + {{8{srcB[7]}}, srcB[7:0]})));

  // R7: 64-bit lane 0, top half, unsigned subtract
  a_r7_dbl_sub: assert property (@(posedge clk) disable iff (!rstN)
    (legalIn && instr[23:22] == 2'd3 && instr[12:10] == 3'b111) |=>
    (outResult[63:0] == $past(srcA[63:0] - {32'd0, srcB[63:32]})));

  // R2: the two flags never coexist
  a_r2_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(outValid && outIllegal));
endmodule

bind vwide_addsub vwide_addsub_chk #(.VW(VW)) u_chk (.*);

// File: tb/vwide_addsub_tb.sv
`timescale 1ns/1ps
module vwide_addsub_tb;
  localparam int VW = 128;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [31:0]   instr = '0;
  logic [VW-1:0] srcA = '0;
  logic [VW-1:0] srcB = '0;
  logic          outValid;
  logic          outIllegal;
  logic [4:0]    outRd;
  logic [VW-1:0] outResult;

  int checks = 0;
  int errors = 0;
  logic [VW-1:0] lastRes = '0;
  logic [4:0]    lastRd = '0;

  always #2.5 clk = ~clk;

  vwide_addsub #(.VW(VW)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instr(instr),
    .srcA(srcA), .srcB(srcB), .outValid(outValid), .outIllegal(outIllegal),
    .outRd(outRd), .outResult(outResult)
  );

  task automatic check(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkInstr(input logic [1:0] sz, input logic [2:0] op,
                                          input logic [4:0] rd);
    return {8'h45, sz, 1'b0, 5'd7, 3'b010, op, 5'd3, rd};
  endfunction

  function automatic logic [VW-1:0] model(input logic [1:0] sz, input logic [2:0] op,
                                          input logic [VW-1:0] a, input logic [VW-1:0] b);
    logic [VW-1:0] r = '0;
    int lw = 8 << sz;
    int nw = lw / 2;
    logic [63:0] lmask = (lw == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << lw) - 64'd1);
    logic [63:0] nmask = (64'd1 << nw) - 64'd1;
    for (int l = 0; l < VW / lw; l++) begin
      logic [63:0] av = 64'(a >> (l * lw)) & lmask;
      logic [63:0] bv = 64'(b >> (l * lw)) & lmask;
      logic [63:0] nv = (op[0] ? (bv >> nw) : bv) & nmask;
      logic [63:0] ev = nv;
      logic [63:0] rv;
      if (!op[1] && nv[nw-1]) ev = nv | (lmask & ~nmask);
      rv = (op[2] ? (av - ev) : (av + ev)) & lmask;
      r = r | (VW'(rv) << (l * lw));
    end
    return r;
  endfunction

  task automatic issue(input logic v, input logic [31:0] w,
                       input logic [VW-1:0] a, input logic [VW-1:0] b);
    @(negedge clk);
    inValid = v; instr = w; srcA = a; srcB = b;
    @(posedge clk);
    #1;
    inValid = 1'b0;
  endtask

  task automatic runLegal(input logic [1:0] sz, input logic [2:0] op,
                          input logic [VW-1:0] a, input logic [VW-1:0] b);
    logic [4:0] rd = 5'($urandom);
    logic [VW-1:0] exp = model(sz, op, a, b);
    string tag = $sformatf("R3 %s R6 R7 R8 sz=%0d op=%0d", op[0] ? "R5" : "R4", sz, op);
    issue(1'b1, mkInstr(sz, op, rd), a, b);
    check(tag, outResult, exp);
    check("R9 valid", VW'(outValid), VW'(1));
    check("R9 rd", VW'(outRd), VW'(rd));
    check("R2 no illegal on legal", VW'(outIllegal), VW'(0));
    lastRes = exp; lastRd = rd;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset valid", VW'(outValid), VW'(0));
    check("R10 reset illegal", VW'(outIllegal), VW'(0));
    check("R10 reset rd", VW'(outRd), VW'(0));
    check("R10 reset result", outResult, '0);
    @(negedge clk); rstN = 1'b1;

    // R6 R5 corner: top half 0x80 in 16-bit lanes
    for (int op = 0; op < 8; op++) begin
      if (op[0]) begin
        logic [VW-1:0] b = {8{16'h8000}};
        issue(1'b1, mkInstr(2'd1, 3'(op), 5'd9), '0, b);
        if (op[2] == 1'b0)
          check("R6 R5 0x80 top add", VW'(outResult[15:0]), VW'(op[1] ? 16'h0080 : 16'hFF80));
        else
          check("R6 R5 0x80 top sub", VW'(outResult[15:0]), VW'(op[1] ? 16'hFF80 : 16'h0080));
        lastRes = outResult;
      end
    end

    // R3 R4 R5 R6 R7 R8 sweep
    for (int sz = 1; sz < 4; sz++) begin
      for (int op = 0; op < 8; op++) begin
        runLegal(2'(sz), 3'(op), {VW/8{8'h80}}, {VW/8{8'h80}});
        runLegal(2'(sz), 3'(op), {VW{1'b1}}, {VW{1'b1}});
        runLegal(2'(sz), 3'(op), '0, {VW/8{8'h7F}});
        runLegal(2'(sz), 3'(op), {VW/16{16'h8001}}, {VW/16{16'h00FF}});
        for (int k = 0; k < 12; k++)
          runLegal(2'(sz), 3'(op), {$urandom, $urandom, $urandom, $urandom},
                   {$urandom, $urandom, $urandom, $urandom});
      end
    end

    // R2: reserved size right after a legal word
    for (int op = 0; op < 8; op++) begin
      runLegal(2'd2, 3'(op), {4{32'h1234_5678}}, {4{32'h8765_4321}});
      issue(1'b1, mkInstr(2'd0, 3'(op), 5'd30), {VW{1'b1}}, {VW{1'b1}});
      check("R2 illegal flag", VW'(outIllegal), VW'(1));
      check("R2 no valid", VW'(outValid), VW'(0));
      check("R2 result held", outResult, lastRes);
      check("R2 rd held", VW'(outRd), VW'(lastRd));
    end

    // R1: words outside the family and idle cycles
    begin
      logic [31:0] bad [4];
      bad[0] = mkInstr(2'd1, 3'd0, 5'd1) | 32'h0020_0000;
      bad[1] = (mkInstr(2'd2, 3'd3, 5'd2) & ~32'h0000_E000) | 32'h0000_6000;
      bad[2] = (mkInstr(2'd3, 3'd5, 5'd3) & ~32'hFF00_0000) | 32'h4400_0000;
      bad[3] = mkInstr(2'd0, 3'd1, 5'd4) | 32'h0020_0000;
      for (int i = 0; i < 4; i++) begin
        issue(1'b1, bad[i], {VW{1'b1}}, {VW{1'b1}});
        check("R1 no valid", VW'(outValid), VW'(0));
        check("R1 no illegal", VW'(outIllegal), VW'(0));
        check("R1 result held", outResult, lastRes);
      end
      issue(1'b0, mkInstr(2'd1, 3'd0, 5'd5), {VW{1'b1}}, {VW{1'b1}});
      check("R1 idle no valid", VW'(outValid), VW'(0));
      check("R1 idle result held", outResult, lastRes);
      issue(1'b0, mkInstr(2'd0, 3'd0, 5'd5), '0, '0);
      check("R1 idle no illegal", VW'(outIllegal), VW'(0));
    end

    // R10: reset mid-run clears state
    @(negedge clk); rstN = 1'b0;
    @(posedge clk); #1;
    check("R10 mid reset result", outResult, '0);
    check("R10 mid reset valid", VW'(outValid), VW'(0));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule